// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the transfer engine of an I2C master. Software, or a register front end, pushes 11-bit command words into a transmit queue. Each word either carries a byte to send or asks for a byte to be read. It can also ask for a repeated START before its byte and a STOP after it. The engine turns these words into byte-level bus operations: START, repeated START, STOP, byte write and byte read. It hands each operation to a bit engine through a request/done handshake. The target address comes from a target word, and bit 12 of that word selects 10-bit addressing. Received bytes are placed in a receive queue.

Address NACKs, data NACKs, general-call misuse, start-byte faults and lost arbitration end the transfer. A STOP is sent unless arbitration was lost. The engine then records a one-hot abort cause, discards everything queued in both directions and waits for an explicit clear. When the transmit queue runs dry with no STOP pending, the engine keeps the bus: SCL stays low and it waits for more words. It does the same when a read finds the receive queue full.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command word holds the byte in bits 7:0, a read request in bit 8, STOP-after in bit 9 and repeated-START-before in bit 10. Bit-engine operation codes are START=0, RESTART=1, STOP=2, WRITE=3 and READ=4. A write word produces one WRITE of its byte. While a request waits for done, its code and byte do not change.
- R2: A transfer opens with START and then one address byte. In 7-bit mode the address byte is target bits 6:0 followed by the direction bit (1 = read).
- R3: When target bit 12 is set, the engine sends 11110,t9,t8,0 and then target bits 7:0. A read continues with RESTART and 11110,t9,t8,1.
- R4: Each READ stores the byte returned by the bit engine in the receive queue. The master acknowledge (`be_rd_ack`) is 0 on the read that carries STOP and 1 on every other read.
- R5: A word with STOP is followed by a STOP operation. After that STOP the engine is idle and `activity` is low.
- R6: The address phase is sent again when a word has the restart flag or reverses direction. It is preceded by RESTART when restarts are enabled, and by STOP and then START when they are not.
- R7: When the transmit queue is empty and no STOP has been issued, the engine holds the bus with `scl_hold` high and issues no operation. It resumes with the next word.
- R8: A read word is not issued while the receive queue is full. `scl_hold` stays high until a byte is popped.
- R9: A NACK sets one abort-cause bit and is followed by a STOP. The bits are: bit 0 for the 7-bit address, bit 1 for the first 10-bit header (either direction), bit 2 for the second 10-bit byte, bit 3 for data and bit 4 for the general-call address. Both queues are then flushed, and nothing further is issued until `abort_clr`.
- R10: Lost arbitration reported with any done sets cause bit 9. No further operation is issued, not even a STOP.
- R11: Two cases abort without proceeding. A 10-bit read with restarts disabled sets cause bit 8. Start-byte mode (`special`=2) with restarts disabled sets bit 7. Neither issues an operation when the bus is idle.
- R12: In general-call mode (`special`=1) the address byte is 0x00. A read word in this mode aborts with cause bit 5.
- R13: In start-byte mode the engine sends START, WRITE 0x01, RESTART and then the normal address. If the start byte is acknowledged, the engine sets cause bit 6 and sends STOP.
- R14: `enable_status` follows `enable` one cycle later, and changes only while `activity` is low. Dropping `enable` while the bus is held ends the transfer with a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Enable request |
| enable_status | output | 1 | Enable state actually in force |
| tgt_addr | input | 13 | Target: address in 9:0, bit 12 selects 10-bit |
| restart_en | input | 1 | Allow repeated START |
| special | input | 2 | 0 normal, 1 general call, 2 start byte |
| cmd_push | input | 1 | Push a command word |
| cmd_word | input | 11 | Command word |
| cmd_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Pop a received byte |
| rx_data | output | 8 | Head of receive queue |
| rx_empty | output | 1 | Receive queue empty |
| be_req | output | 1 | Operation request to bit engine |
| be_op | output | 3 | Operation code |
| be_wdata | output | 8 | Byte to write |
| be_rd_ack | output | 1 | Acknowledge to give on a read |
| be_done | input | 1 | Operation finished (one cycle) |
| be_ack | input | 1 | Target acknowledged the written byte |
| be_arb | input | 1 | Arbitration lost during the operation |
| be_rdata | input | 8 | Byte read from the bus |
| activity | output | 1 | Transfer in progress |
| scl_hold | output | 1 | Bus held low waiting for space or words |
| tx_abort | output | 1 | An abort cause is latched |
| abort_cause | output | 10 | One-hot abort cause |
| abort_clr | input | 1 | Clear the latched cause |

## Verification
The hardest states to reach are the ones where the engine sits mid-transfer with the bus held. One is a 10-bit read whose direction reversal arrives after a write has already started. Another is a full receive queue with a read still pending. The bench reaches them through ordering alone. It queues a write followed by a read, and it queues more reads than the receive queue holds without popping. A bit-engine model logs every operation and injects a NACK or lost arbitration at a chosen operation index. This lets each abort cause be raised at its exact byte, in a sweep over address width, direction and restart setting.

// File: rtl/i2cseq_pkg.sv
// Package: shared types and constants of the I2C command sequencer.
// Assumes: command layout and cause bit positions are fixed by the brief.
package i2cseq_pkg;
    localparam int CMD_W   = 11;
    localparam int CAUSE_W = 10;

    localparam int C_ADDR7_NACK = 0;
    localparam int C_HDR1_NACK  = 1;
    localparam int C_HDR2_NACK  = 2;
    localparam int C_DATA_NACK  = 3;
    localparam int C_GC_NACK    = 4;
    localparam int C_GC_READ    = 5;
    localparam int C_SB_ACKED   = 6;
    localparam int C_SB_NORS    = 7;
    localparam int C_RD10_NORS  = 8;
    localparam int C_ARB_LOST   = 9;

    typedef struct packed {
        logic       restart;
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PREP, ST_COND, ST_SBYTE, ST_ADDR1, ST_ADDR2,
        ST_RS10, ST_ADDR3, ST_DATA, ST_WAIT, ST_STOP, ST_ABSTOP, ST_HALT
    } seq_st_e;
endpackage

// File: rtl/i2cseq_fifo.sv
// Module: synchronous FIFO with flush, head visible without popping.
// Assumes: DEPTH is a power of two and at least 2; push when full is dropped;
// flush wins over push and pop in the same cycle.
module i2cseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_MAX);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/i2cseq_engine.sv
// Module: command-word sequencer FSM. Issues one bus operation at a time to
// the bit engine, builds the address phase, stores read data, detects aborts.
// Assumes: be_done is a one-cycle pulse that only arrives while be_req is high.
module i2cseq_engine
    import i2cseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    output logic               en_status,
    input  logic [12:0]        tgt,
    input  logic               restart_en,
    input  logic [1:0]         special,
    input  cmd_t               tx_head,
    input  logic               tx_empty,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [7:0]         rx_wdata,
    output logic               be_req,
    output logic [2:0]         be_op,
    output logic [7:0]         be_wdata,
    output logic               be_rd_ack,
    input  logic               be_done,
    input  logic               be_ack,
    input  logic               be_arb,
    input  logic [7:0]         be_rdata,
    output logic               activity,
    output logic               scl_hold,
    output logic [CAUSE_W-1:0] cause,
    input  logic               abort_clr
);
    seq_st_e             state, st_n;
    logic                on_bus, on_bus_n;
    logic                dir, dir_n;
    logic                sb_done, sb_n;
    logic [CAUSE_W-1:0]  cause_n;
    logic                en_q;
    logic                ten, gc, sb, hs;
    logic [7:0]          hdr;

    assign ten      = tgt[12];
    assign gc       = (special == 2'd1);
    assign sb       = (special == 2'd2);
    assign hdr      = {5'b11110, tgt[9:8], 1'b0};
    assign hs       = be_req && be_done;
    assign rx_wdata = be_rdata;
    assign be_rd_ack = !tx_head.stop;
    assign cause    = 0 ? '0 : cause_n_q();
    assign en_status = en_q;
    assign activity = (state != ST_IDLE) && (state != ST_HALT);
    assign scl_hold = on_bus && (((state == ST_WAIT) && tx_empty) ||
                                 ((state == ST_DATA) && tx_head.rd && rx_full));

    logic [CAUSE_W-1:0] cause_q;
    function automatic logic [CAUSE_W-1:0] cause_n_q();
        return cause_q;
    endfunction

    // Operation presented to the bit engine in each state.
    always_comb begin
        be_req   = 1'b0;
        be_op    = OP_WRITE;
        be_wdata = 8'h00;
        case (state)
            ST_COND: begin
                be_req = 1'b1;
                be_op  = !on_bus ? OP_START : (restart_en ? OP_RESTART : OP_STOP);
            end
            ST_SBYTE: begin
                be_req   = 1'b1;
                be_wdata = 8'h01;
            end
            ST_ADDR1: begin
                be_req   = 1'b1;
                be_wdata = gc ? 8'h00 : (ten ? hdr : {tgt[6:0], dir});
            end
            ST_ADDR2: begin
                be_req   = 1'b1;
                be_wdata = tgt[7:0];
            end
            ST_RS10: begin
                be_req = 1'b1;
                be_op  = OP_RESTART;
            end
            ST_ADDR3: begin
                be_req   = 1'b1;
                be_wdata = hdr | 8'h01;
            end
            ST_DATA: begin
                be_req   = !(tx_head.rd && rx_full);
                be_op    = tx_head.rd ? OP_READ : OP_WRITE;
                be_wdata = tx_head.data;
            end
            ST_STOP, ST_ABSTOP: begin
                be_req = 1'b1;
                be_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    // Next-state, abort detection and queue strobes.
    always_comb begin
        st_n     = state;
        on_bus_n = on_bus;
        dir_n    = dir;
        sb_n     = sb_done;
        cause_n  = cause_q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        if (hs && be_arb && state != ST_ABSTOP) begin
            cause_n[C_ARB_LOST] = 1'b1;
            on_bus_n = 1'b0;
            st_n     = ST_HALT;
        end else begin
            case (state)
                ST_IDLE: begin
                    sb_n = 1'b0;
                    if (en_q && !tx_empty && cause_q == '0) st_n = ST_PREP;
                end
                ST_PREP: begin
                    dir_n = tx_head.rd;
                    st_n  = ST_COND;
                    if (gc && tx_head.rd) begin
                        cause_n[C_GC_READ] = 1'b1;
                        st_n = on_bus ? ST_ABSTOP : ST_HALT;
                    end else if (sb && !restart_en) begin
                        cause_n[C_SB_NORS] = 1'b1;
                        st_n = on_bus ? ST_ABSTOP : ST_HALT;
                    end else if (ten && tx_head.rd && !restart_en) begin
                        cause_n[C_RD10_NORS] = 1'b1;
                        st_n = on_bus ? ST_ABSTOP : ST_HALT;
                    end
                end
                ST_COND: if (hs) begin
                    if (on_bus && !restart_en) begin
                        on_bus_n = 1'b0;
                    end else begin
                        on_bus_n = 1'b1;
                        st_n = (sb && !sb_done) ? ST_SBYTE : ST_ADDR1;
                    end
                end
                ST_SBYTE: if (hs) begin
                    if (be_ack) begin
                        cause_n[C_SB_ACKED] = 1'b1;
                        st_n = ST_ABSTOP;
                    end else begin
                        sb_n = 1'b1;
                        st_n = ST_COND;
                    end
                end
                ST_ADDR1: if (hs) begin
                    if (!be_ack) begin
                        if (gc)       cause_n[C_GC_NACK]    = 1'b1;
                        else if (ten) cause_n[C_HDR1_NACK]  = 1'b1;
                        else          cause_n[C_ADDR7_NACK] = 1'b1;
                        st_n = ST_ABSTOP;
                    end else begin
                        st_n = (ten && !gc) ? ST_ADDR2 : ST_DATA;
                    end
                end
                ST_ADDR2: if (hs) begin
                    if (!be_ack) begin
                        cause_n[C_HDR2_NACK] = 1'b1;
                        st_n = ST_ABSTOP;
                    end else begin
                        st_n = dir ? ST_RS10 : ST_DATA;
                    end
                end
                ST_RS10: if (hs) st_n = ST_ADDR3;
                ST_ADDR3: if (hs) begin
                    if (!be_ack) begin
                        cause_n[C_HDR1_NACK] = 1'b1;
                        st_n = ST_ABSTOP;
                    end else begin
                        st_n = ST_DATA;
                    end
                end
                ST_DATA: if (hs) begin
                    if (!tx_head.rd && !be_ack) begin
                        cause_n[C_DATA_NACK] = 1'b1;
                        st_n = ST_ABSTOP;
                    end else begin
                        tx_pop  = 1'b1;
                        rx_push = tx_head.rd;
                        st_n    = tx_head.stop ? ST_STOP : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!tx_empty)
                        st_n = (tx_head.restart || tx_head.rd != dir) ? ST_PREP : ST_DATA;
                    else if (!enable)
                        st_n = ST_STOP;
                end
                ST_STOP: if (hs) begin
                    on_bus_n = 1'b0;
                    st_n     = ST_IDLE;
                end
                ST_ABSTOP: if (hs) begin
                    on_bus_n = 1'b0;
                    st_n     = ST_HALT;
                end
                ST_HALT: if (abort_clr) begin
                    cause_n = '0;
                    st_n    = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            on_bus  <= 1'b0;
            dir     <= 1'b0;
            sb_done <= 1'b0;
            cause_q <= '0;
        end else begin
            state   <= st_n;
            on_bus  <= on_bus_n;
            dir     <= dir_n;
            sb_done <= sb_n;
            cause_q <= cause_n;
        end
    end

    // Enable status: takes the request only while no transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  en_q <= 1'b0;
        else if (state == ST_IDLE || state == ST_HALT) en_q <= enable;
    end

    // R1
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && !be_done |=> be_req && $stable(be_op) && $stable(be_wdata));
    // R14
    en_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_status != $past(en_status)) |-> !$past(activity));
    // R8
    rx_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    // R10
    arb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && be_done && be_arb && state != ST_ABSTOP |=> !be_req && !activity);
    // R5
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && be_done && !be_arb && state == ST_STOP |=> !activity);
endmodule

// File: rtl/i2c_cmd_sequencer.sv
// Module: top of the I2C master command sequencer. Joins the transmit command
// queue, the receive byte queue and the sequencing FSM.
// Assumes: queue depths are powers of two; the bit engine follows the
// request/done handshake described in the brief.
module i2c_cmd_sequencer
    import i2cseq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    output logic         enable_status,
    input  logic [12:0]  tgt_addr,
    input  logic         restart_en,
    input  logic [1:0]   special,
    input  logic         cmd_push,
    input  logic [10:0]  cmd_word,
    output logic         cmd_full,
    input  logic         rx_pop,
    output logic [7:0]   rx_data,
    output logic         rx_empty,
    output logic         be_req,
    output logic [2:0]   be_op,
    output logic [7:0]   be_wdata,
    output logic         be_rd_ack,
    input  logic         be_done,
    input  logic         be_ack,
    input  logic         be_arb,
    input  logic [7:0]   be_rdata,
    output logic         activity,
    output logic         scl_hold,
    output logic         tx_abort,
    output logic [9:0]   abort_cause,
    input  logic         abort_clr
);
    logic [CMD_W-1:0] tx_dout;
    cmd_t             tx_head;
    logic             tx_empty, tx_pop, rx_full, rx_push, flush;
    logic [7:0]       rx_wdata;

    assign tx_head  = cmd_t'(tx_dout);
    assign tx_abort = |abort_cause;
    assign flush    = tx_abort;

    i2cseq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(cmd_push), .din(cmd_word), .pop(tx_pop),
        .dout(tx_dout), .empty(tx_empty), .full(cmd_full)
    );

    i2cseq_fifo #(.W(8), .DEPTH(RX_DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .din(rx_wdata), .pop(rx_pop),
        .dout(rx_data), .empty(rx_empty), .full(rx_full)
    );

    i2cseq_engine i_eng (
        .clk(clk), .rst_n(rst_n), .enable(enable), .en_status(enable_status),
        .tgt(tgt_addr), .restart_en(restart_en), .special(special),
        .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .be_req(be_req), .be_op(be_op), .be_wdata(be_wdata), .be_rd_ack(be_rd_ack),
        .be_done(be_done), .be_ack(be_ack), .be_arb(be_arb), .be_rdata(be_rdata),
        .activity(activity), .scl_hold(scl_hold), .cause(abort_cause),
        .abort_clr(abort_clr)
    );

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> rx_empty);
    // R9
    abort_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(abort_cause));
endmodule

// File: tb/test_i2c_cmd_sequencer.sv
module test_i2c_cmd_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        enable_status;
    logic [12:0] tgt_addr = 13'h02C;
    logic        restart_en = 1'b1;
    logic [1:0]  special = 2'd0;
    logic        cmd_push = 1'b0;
    logic [10:0] cmd_word = '0;
    logic        cmd_full;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_empty;
    logic        be_req;
    logic [2:0]  be_op;
    logic [7:0]  be_wdata;
    logic        be_rd_ack;
    logic        be_done = 1'b0;
    logic        be_ack = 1'b0;
    logic        be_arb = 1'b0;
    logic [7:0]  be_rdata = '0;
    logic        activity, scl_hold, tx_abort;
    logic [9:0]  abort_cause;
    logic        abort_clr = 1'b0;

    int checks = 0;
    int fails  = 0;
    int n_log  = 0;
    int nack_at = -1;
    int arb_at  = -1;
    int log_op  [512];
    int log_dat [512];
    int exp_op  [32];
    int exp_dat [32];
    int n_exp;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    i2c_cmd_sequencer i_i2c_cmd_sequencer (.*);

    // Bit engine model: logs each operation and answers after two cycles.
    always begin
        @(negedge clk);
        if (be_req) begin
            automatic int op = int'(be_op);
            automatic int d  = int'(be_wdata);
            automatic int a  = int'(be_rd_ack);
            automatic int idx;
            repeat (2) @(negedge clk);
            idx = n_log;
            log_op[idx]  = op;
            log_dat[idx] = (op == 4) ? a : d;
            n_log = n_log + 1;
            be_ack   = (idx != nack_at);
            be_arb   = (idx == arb_at);
            be_rdata = 8'h5A ^ idx[7:0];
            be_done  = 1'b1;
            @(negedge clk);
            be_done = 1'b0;
            be_arb  = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ex(input int op, input int d);
        exp_op[n_exp]  = op;
        exp_dat[n_exp] = d;
        n_exp++;
    endtask

    task automatic cmp_ops(input int base, input string tag);
        automatic int bad = -1;
        if (n_log - base != n_exp) begin
            chk(1'b0, {tag, " op count"}, n_log - base, n_exp);
        end else begin
            for (int i = 0; i < n_exp; i++) begin
                if (bad < 0) begin
                    if (log_op[base+i] != exp_op[i]) bad = i;
                    else if ((exp_op[i] == 3 || exp_op[i] == 4) && log_dat[base+i] != exp_dat[i]) bad = i;
                end
            end
            if (bad < 0) chk(1'b1, tag, 0, 0);
            else chk(1'b0, {tag, " op/data"}, log_op[base+bad]*256 + log_dat[base+bad],
                     exp_op[bad]*256 + exp_dat[bad]);
        end
    endtask

    task automatic push(input bit rs, input bit st, input bit rd, input logic [7:0] d);
        cmd_word = {rs, st, rd, d};
        cmd_push = 1'b1;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic settle();
        automatic int t = 0;
        repeat (4) @(negedge clk);
        while (activity && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_abort();
        abort_clr = 1'b1;
        @(negedge clk);
        abort_clr = 1'b0;
        @(negedge clk);
    endtask

    // Address bytes for 7-bit 0x2C and 10-bit 0x2B5.
    localparam int A7W = 8'h58, A7R = 8'h59, H0 = 8'hF4, H1 = 8'hF5, LO = 8'hB5;

    task automatic addr_w(input bit ten);
        if (ten) begin ex(3, H0); ex(3, LO); end
        else ex(3, A7W);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        automatic int base;
        automatic int pos;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(!activity && !enable_status && !tx_abort && rx_empty && !scl_hold && !be_req,
            "R14 reset outputs", {activity, enable_status, tx_abort, rx_empty, scl_hold, be_req}, 6'b000100);

        // R14: enable status lags by one cycle
        enable = 1'b1;
        #1 chk(enable_status == 1'b0, "R14 status before edge", enable_status, 0);
        @(negedge clk);
        chk(enable_status == 1'b1, "R14 status after one cycle", enable_status, 1);

        // R1 R2 R3 R4 R6: sweep address width x second direction x restart
        for (int ten = 0; ten < 2; ten++) begin
            for (int rd = 0; rd < 2; rd++) begin
                for (int rs = 0; rs < 2; rs++) begin
                    automatic int k = ten*4 + rd*2 + rs;
                    automatic int rpos = -1;
                    automatic int ecause = 0;
                    tgt_addr   = ten ? 13'h12B5 : 13'h002C;
                    restart_en = rs[0];
                    base = n_log; n_exp = 0;
                    push(1'b0, 1'b0, 1'b0, 8'h30 + k[7:0]);
                    push(1'b0, 1'b1, rd[0], 8'h40 + k[7:0]);
                    ex(0, 0); addr_w(ten[0]); ex(3, 8'h30 + k);
                    if (rd && ten && !rs) begin
                        ex(2, 0);
                        ecause = 1 << 8;
                    end else if (rd) begin
                        if (rs) ex(1, 0); else begin ex(2, 0); ex(0, 0); end
                        if (ten) begin ex(3, H0); ex(3, LO); ex(1, 0); ex(3, H1); end
                        else ex(3, A7R);
                        rpos = n_exp;
                        ex(4, 0); ex(2, 0);
                    end else begin
                        ex(3, 8'h40 + k); ex(2, 0);
                    end
                    settle();
                    cmp_ops(base, $sformatf("R3 R6 sweep ten=%0d rd=%0d rs=%0d", ten, rd, rs));
                    chk(int'(abort_cause) == ecause, "R11 R6 sweep cause", abort_cause, ecause);
                    if (rpos >= 0) begin
                        chk(!rx_empty && rx_data == (8'h5A ^ 8'(base + rpos)), "R4 read byte stored",
                            rx_data, 8'h5A ^ 8'(base + rpos));
                        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
                    end
                    if (ecause != 0) clear_abort();
                    chk(!activity, "R5 idle after stop", activity, 0);
                end
            end
        end
        restart_en = 1'b1;

        // R7: hold with empty queue, resume on next word
        tgt_addr = 13'h002C;
        base = n_log; n_exp = 0;
        push(1'b0, 1'b0, 1'b0, 8'h71);
        repeat (30) @(negedge clk);
        chk(scl_hold && activity && (n_log - base == 3) && !be_req, "R7 bus held", n_log - base, 3);
        push(1'b0, 1'b1, 1'b0, 8'h72);
        settle();
        ex(0, 0); ex(3, A7W); ex(3, 8'h71); ex(3, 8'h72); ex(2, 0);
        cmp_ops(base, "R7 resume after hold");

        // R14: disable while held ends with STOP, status drops afterwards
        base = n_log; n_exp = 0;
        push(1'b0, 1'b0, 1'b0, 8'h73);
        repeat (30) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(enable_status == 1'b1, "R14 status held while active", enable_status, 1);
        settle();
        chk(enable_status == 1'b0, "R14 status dropped when idle", enable_status, 0);
        ex(0, 0); ex(3, A7W); ex(3, 8'h73); ex(2, 0);
        cmp_ops(base, "R14 disable ends transfer");
        enable = 1'b1;
        repeat (2) @(negedge clk);

        // R8: five reads into a four-entry receive queue
        base = n_log; n_exp = 0;
        for (int i = 0; i < 5; i++) push(1'b0, (i == 4), 1'b1, 8'h00);
        repeat (60) @(negedge clk);
        chk(scl_hold && (n_log - base == 6) && !be_req, "R8 stall on full queue", n_log - base, 6);
        chk(rx_data == (8'h5A ^ 8'(base + 2)), "R4 first read byte", rx_data, 8'h5A ^ 8'(base + 2));
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        settle();
        ex(0, 0); ex(3, A7R); ex(4, 1); ex(4, 1); ex(4, 1); ex(4, 1); ex(4, 0); ex(2, 0);
        cmp_ops(base, "R8 R4 reads resume and ack pattern");
        for (int i = 3; i < 7; i++) begin
            chk(!rx_empty && rx_data == (8'h5A ^ 8'(base + i)), "R4 queued read byte",
                rx_data, 8'h5A ^ 8'(base + i));
            rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
        end
        chk(rx_empty, "R8 queue drained", rx_empty, 1);

        // R9: NACK at every address byte and at data, both widths
        for (int ten = 0; ten < 2; ten++) begin
            for (int p = 1; p <= 2 + ten; p++) begin
                automatic int ec;
                tgt_addr = ten ? 13'h12B5 : 13'h002C;
                base = n_log; n_exp = 0;
                nack_at = base + p;
                push(1'b0, 1'b0, 1'b0, 8'h91);
                push(1'b0, 1'b1, 1'b0, 8'h92);
                settle();
                nack_at = -1;
                ex(0, 0);
                if (ten) begin ex(3, H0); if (p >= 2) ex(3, LO); if (p >= 3) ex(3, 8'h91); end
                else begin ex(3, A7W); if (p >= 2) ex(3, 8'h91); end
                ex(2, 0);
                if (p == 1 + ten + 1) ec = 1 << 3;
                else if (!ten) ec = 1 << 0;
                else ec = (p == 1) ? (1 << 1) : (1 << 2);
                cmp_ops(base, $sformatf("R9 nack ten=%0d pos=%0d ops", ten, p));
                chk(int'(abort_cause) == ec && tx_abort, "R9 nack cause", abort_cause, ec);
                clear_abort();
                repeat (20) @(negedge clk);
                chk(n_log == base + n_exp && !activity && rx_empty, "R9 queues flushed",
                    n_log - base, n_exp);
            end
        end

        // R10: lost arbitration, no STOP
        tgt_addr = 13'h002C;
        base = n_log; n_exp = 0;
        arb_at = base + 1;
        push(1'b0, 1'b0, 1'b0, 8'hA1);
        push(1'b0, 1'b1, 1'b0, 8'hA2);
        settle();
        arb_at = -1;
        ex(0, 0); ex(3, A7W);
        cmp_ops(base, "R10 arb lost no stop");
        chk(int'(abort_cause) == (1 << 9), "R10 arb cause", abort_cause, 1 << 9);
        clear_abort();

        // R11: 10-bit read from idle with restart disabled
        tgt_addr = 13'h12B5; restart_en = 1'b0;
        base = n_log; n_exp = 0;
        push(1'b0, 1'b1, 1'b1, 8'h00);
        settle();
        cmp_ops(base, "R11 10-bit read no ops");
        chk(int'(abort_cause) == (1 << 8), "R11 10-bit read cause", abort_cause, 1 << 8);
        clear_abort();

        // R11: start byte with restart disabled
        tgt_addr = 13'h002C; special = 2'd2;
        base = n_log; n_exp = 0;
        push(1'b0, 1'b1, 1'b0, 8'hB1);
        settle();
        cmp_ops(base, "R11 start byte no ops");
        chk(int'(abort_cause) == (1 << 7), "R11 start byte cause", abort_cause, 1 << 7);
        clear_abort();
        restart_en = 1'b1;

        // R13: start byte not acknowledged -> normal transfer
        base = n_log; n_exp = 0;
        nack_at = base + 1;
        push(1'b0, 1'b1, 1'b0, 8'hB2);
        settle();
        nack_at = -1;
        ex(0, 0); ex(3, 8'h01); ex(1, 0); ex(3, A7W); ex(3, 8'hB2); ex(2, 0);
        cmp_ops(base, "R13 start byte sequence");
        chk(abort_cause == '0, "R13 no abort", abort_cause, 0);

        // R13: start byte acknowledged -> abort
        base = n_log; n_exp = 0;
        push(1'b0, 1'b1, 1'b0, 8'hB3);
        settle();
        ex(0, 0); ex(3, 8'h01); ex(2, 0);
        cmp_ops(base, "R13 start byte acked ops");
        chk(int'(abort_cause) == (1 << 6), "R13 start byte acked cause", abort_cause, 1 << 6);
        clear_abort();

        // R12: general call write, nack and read
        special = 2'd1;
        base = n_log; n_exp = 0;
        push(1'b0, 1'b1, 1'b0, 8'hC1);
        settle();
        ex(0, 0); ex(3, 8'h00); ex(3, 8'hC1); ex(2, 0);
        cmp_ops(base, "R12 general call write");
        base = n_log; n_exp = 0;
        nack_at = base + 1;
        push(1'b0, 1'b1, 1'b0, 8'hC2);
        settle();
        nack_at = -1;
        ex(0, 0); ex(3, 8'h00); ex(2, 0);
        cmp_ops(base, "R12 R9 general call nack ops");
        chk(int'(abort_cause) == (1 << 4), "R9 general call nack cause", abort_cause, 1 << 4);
        clear_abort();
        base = n_log; n_exp = 0;
        push(1'b0, 1'b1, 1'b1, 8'h00);
        settle();
        cmp_ops(base, "R12 general call read no ops");
        chk(int'(abort_cause) == (1 << 5), "R12 general call read cause", abort_cause, 1 << 5);
        clear_abort();
        special = 2'd0;

        // R6: explicit restart flag, same direction
        base = n_log; n_exp = 0;
        push(1'b0, 1'b0, 1'b0, 8'hD1);
        push(1'b1, 1'b1, 1'b0, 8'hD2);
        settle();
        ex(0, 0); ex(3, A7W); ex(3, 8'hD1); ex(1, 0); ex(3, A7W); ex(3, 8'hD2); ex(2, 0);
        cmp_ops(base, "R6 restart flag");

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule